// File: doc/BRIEF.md
# Read-Only Identifier Region Reader

This block answers bus transactions aimed at a small, read-only identifier space that sits beside a byte-addressable main array. The space is 32 bytes long and is reached with its own control code. It holds a 128-bit serial number in its lower half and a network identifier, 48 or 64 bits wide, in its top bytes. A protocol engine handles the bit-level serial framing. It hands this block byte-level events: start, stop, a received byte, and "the next transmit byte was taken". The block returns an acknowledge decision, the byte to transmit and the shared address pointer.

The pointer is shared with the main array. The main array reloads it through a load port whenever it accesses its own storage. In this space, only the low five pointer bits select a byte, and bit 7 of the pointer reads as 1. A dummy write, which is a device byte with the write flag followed by one word-address byte, places the pointer. Current-address reads and sequential reads then stream bytes. A sequential read wraps from the last identifier byte back to the first serial-number byte. Data bytes that follow the word address are refused, and the stored contents cannot be changed. The serial number, the organisation prefix, the extension bytes and the 48/64-bit layout are all parameters. An elaboration check rejects 64-bit contents whose first two extension bytes are FFFEh or FFFFh.

Top module: `ext_id_reader`

## Requirements
- R1: A device byte is acknowledged only when bits 7:4 are 1011b and bits 3:1 equal `strap_i`. Bit 0 = 1 selects a read and bit 0 = 0 selects a dummy write. Any other device byte is not acknowledged, and the block stays unselected.
- R2: The byte that follows an acknowledged dummy-write device byte is acknowledged. It sets `ptr_o` to 80h plus its low five bits, so 1Dh gives 9Dh.
- R3: Offsets 80h–8Fh return the serial number, most significant byte first at 80h.
- R4: With the 64-bit layout, 98h–9Fh return the prefix bytes FCh, C2h, 3Dh followed by the five extension bytes, most significant first.
- R5: With the 48-bit layout, 9Ah–9Fh return FCh, C2h, 3Dh followed by the low three extension bytes. 90h–97h read FFh in both layouts, and 98h–99h also read FFh in the 48-bit layout.
- R6: Each taken read byte advances the pointer by one, and the pointer wraps from 9Fh to 80h.
- R7: A read selection keeps the low five bits of whatever the main array last loaded into the pointer and forces the pointer to 80h plus those bits. For example, 4Ch becomes 8Ch.
- R8: Bytes received after the word address, and bytes received while a read is selected, are not acknowledged. They leave the pointer and the region contents unchanged.
- R9: While a read is selected, a main-array pointer load is ignored, including one that arrives in the same cycle as a taken byte. The increment is what takes effect.
- R10: A stop clears `sel_o`. While the block is unselected, `tx_take_i` does not move the pointer.
- R11: After reset, `ptr_o` is 00h, and `sel_o` and `ack_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 3 | Board-strapped device select bits |
| start_i | input | 1 | Start or repeated-start seen by the protocol engine |
| stop_i | input | 1 | Stop seen by the protocol engine |
| byte_valid_i | input | 1 | A byte from the host has been received |
| byte_i | input | 8 | The received byte |
| tx_take_i | input | 1 | The engine has taken `rd_data_o` for transmission |
| arr_ptr_we_i | input | 1 | Main array reloads the shared pointer |
| arr_ptr_i | input | 8 | Pointer value from the main array |
| ack_o | output | 1 | Acknowledge the byte offered this cycle |
| sel_o | output | 1 | Region selected for reading |
| rd_data_o | output | 8 | Byte at the current pointer (FFh when unselected) |
| ptr_o | output | 8 | Shared address pointer |

## Verification
Two pointer writers can land in the same cycle. One is the increment for a byte the engine has taken. The other is a pointer reload from the main array. The bench raises `tx_take_i` and `arr_ptr_we_i` together during a sequential read, with a reload value far from the current pointer. It then checks that `ptr_o` holds the incremented address and not the reload value. A second step applies the reload alone while the read is still selected, and the bench checks that the pointer does not move.

// File: rtl/ext_id_pkg.sv
package ext_id_pkg;

   localparam int          RGN_AW    = 5;
   localparam int          RGN_BYTES = 1 << RGN_AW;
   localparam logic [7:0]  RGN_BASE  = 8'h80;
   localparam logic [3:0]  RGN_CODE  = 4'hB;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WORD,
      ST_HOLD,
      ST_READ
   } ext_st_e;

   // Byte stored at region offset idx for the chosen identifier layout.
   function automatic logic [7:0] ext_byte(input int unsigned idx,
                                           input logic [127:0] sn,
                                           input logic [23:0]  oui,
                                           input logic [39:0]  ext,
                                           input bit           e64);
      logic [63:0] v64;
      logic [47:0] v48;
      v64 = {oui, ext};
      v48 = {oui, ext[23:0]};
      if (idx < 16)
         return 8'(sn >> (8 * (15 - idx)));
      if (e64 && idx >= 24)
         return 8'(v64 >> (8 * (31 - idx)));
      if (!e64 && idx >= 26)
         return 8'(v48 >> (8 * (31 - idx)));
      return 8'hFF;
   endfunction

endpackage

// File: rtl/ext_id_rom.sv
module ext_id_rom
   import ext_id_pkg::*;
#(
   parameter logic [127:0] SERIAL_NUM = 128'h0,
   parameter logic [23:0]  OUI        = 24'hFCC23D,
   parameter logic [39:0]  EXT_ID     = 40'h0,
   parameter bit           EUI64      = 1'b1
) (
   input  logic [RGN_AW-1:0] idx_i,
   output logic [7:0]        data_o
);

   localparam logic [15:0] EXT_HI = EXT_ID[39:24];

   logic [7:0] tbl [RGN_BYTES];

   for (genvar i = 0; i < RGN_BYTES; i++) begin : g_byte
      assign tbl[i] = ext_byte(i, SERIAL_NUM, OUI, EXT_ID, EUI64);
   end

   if (EUI64) begin : g_e64_check
      initial begin
         if (EXT_HI == 16'hFFFE || EXT_HI == 16'hFFFF)
            $error("ext_id_rom: 64-bit extension begins with a reserved value");
      end
   end else begin : g_e48_check
      initial begin
         if (EXT_ID[39:24] != 16'h0)
            $warning("ext_id_rom: upper extension bytes unused in 48-bit layout");
      end
   end

   assign data_o = tbl[idx_i];

endmodule

// File: rtl/ext_id_ctl.sv
module ext_id_ctl
   import ext_id_pkg::*;
#(
   parameter int STRAP_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic               byte_valid_i,
   input  logic [7:0]         byte_i,
   input  logic               tx_take_i,
   input  logic               arr_ptr_we_i,
   input  logic [7:0]         arr_ptr_i,
   output logic               ack_o,
   output logic               sel_o,
   output logic [7:0]         ptr_o
);

   localparam int CODE_LSB = 1 + STRAP_W;

   ext_st_e    st_q, st_n;
   logic [7:0] ptr_q, ptr_n;
   logic       own_upd;
   logic       dev_hit;

   function automatic logic [7:0] in_region(input logic [RGN_AW-1:0] off);
      return RGN_BASE | 8'(off);
   endfunction

   assign dev_hit = (byte_i[7:CODE_LSB] == RGN_CODE) &&
                    (byte_i[CODE_LSB-1:1] == strap_i);

   always_comb begin
      st_n    = st_q;
      ptr_n   = ptr_q;
      ack_o   = 1'b0;
      own_upd = 1'b0;
      if (byte_valid_i) begin
         case (st_q)
            ST_DEV: begin
               if (dev_hit) begin
                  ack_o = 1'b1;
                  if (byte_i[0]) begin
                     st_n    = ST_READ;
                     ptr_n   = in_region(ptr_q[RGN_AW-1:0]);
                     own_upd = 1'b1;
                  end else begin
                     st_n = ST_WORD;
                  end
               end else begin
                  st_n = ST_IDLE;
               end
            end
            ST_WORD: begin
               ack_o   = 1'b1;
               ptr_n   = in_region(byte_i[RGN_AW-1:0]);
               own_upd = 1'b1;
               st_n    = ST_HOLD;
            end
            default: ;
         endcase
      end
      if (st_q == ST_READ && tx_take_i) begin
         ptr_n   = in_region(ptr_q[RGN_AW-1:0] + 1'b1);
         own_upd = 1'b1;
      end
      if (arr_ptr_we_i && !own_upd && st_q != ST_READ)
         ptr_n = arr_ptr_i;
      if (stop_i)
         st_n = ST_IDLE;
      if (start_i)
         st_n = ST_DEV;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         ptr_q <= 8'h00;
      end else begin
         st_q  <= st_n;
         ptr_q <= ptr_n;
      end
   end

   assign sel_o = (st_q == ST_READ);
   assign ptr_o = ptr_q;

endmodule

// File: rtl/ext_id_reader.sv
module ext_id_reader
   import ext_id_pkg::*;
#(
   parameter int           STRAP_W    = 3,
   parameter logic [127:0] SERIAL_NUM = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
   parameter logic [23:0]  OUI        = 24'hFCC23D,
   parameter logic [39:0]  EXT_ID     = 40'h00_1122_3344,
   parameter bit           EUI64      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic               byte_valid_i,
   input  logic [7:0]         byte_i,
   input  logic               tx_take_i,
   input  logic               arr_ptr_we_i,
   input  logic [7:0]         arr_ptr_i,
   output logic               ack_o,
   output logic               sel_o,
   output logic [7:0]         rd_data_o,
   output logic [7:0]         ptr_o
);

   logic [7:0] rom_q;

   ext_id_ctl #(.STRAP_W(STRAP_W)) ctl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .strap_i      (strap_i),
      .start_i      (start_i),
      .stop_i       (stop_i),
      .byte_valid_i (byte_valid_i),
      .byte_i       (byte_i),
      .tx_take_i    (tx_take_i),
      .arr_ptr_we_i (arr_ptr_we_i),
      .arr_ptr_i    (arr_ptr_i),
      .ack_o        (ack_o),
      .sel_o        (sel_o),
      .ptr_o        (ptr_o)
   );

   ext_id_rom #(
      .SERIAL_NUM (SERIAL_NUM),
      .OUI        (OUI),
      .EXT_ID     (EXT_ID),
      .EUI64      (EUI64)
   ) rom_i (
      .idx_i  (ptr_o[RGN_AW-1:0]),
      .data_o (rom_q)
   );

   assign rd_data_o = sel_o ? rom_q : 8'hFF;

endmodule

// File: rtl/ext_id_reader_chk.sv
module ext_id_reader_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       byte_valid_i,
   input logic       tx_take_i,
   input logic       ack_o,
   input logic       sel_o,
   input logic [7:0] ptr_o
);

   assert_ack_needs_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> byte_valid_i);

   assert_no_ack_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> !sel_o);

   assert_ptr_in_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sel_o |-> (ptr_o[7:5] == 3'b100));

   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o && tx_take_i && ptr_o == 8'h9F) |=> (ptr_o == 8'h80));

   assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o && tx_take_i) |=> (ptr_o[4:0] == 5'($past(ptr_o[4:0]) + 5'd1)));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o && !tx_take_i) |=> $stable(ptr_o));

endmodule

bind ext_id_reader ext_id_reader_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .byte_valid_i (byte_valid_i),
   .tx_take_i    (tx_take_i),
   .ack_o        (ack_o),
   .sel_o        (sel_o),
   .ptr_o        (ptr_o)
);

// File: tb/ext_id_reader_tb_top.sv
`timescale 1ns/1ps
module ext_id_reader_tb_top;

   localparam logic [127:0] SN  = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
   localparam logic [39:0]  EXT = 40'h0A_1B2C_3D4E;
   localparam logic [2:0]   STRAP = 3'b101;
   localparam logic [7:0]   DEV_W = {4'hB, STRAP, 1'b0};
   localparam logic [7:0]   DEV_R = {4'hB, STRAP, 1'b1};
   // {word address, byte count}
   localparam int NVEC = 5;
   localparam logic [15:0] VEC [NVEC] = '{16'h8010, 16'h9808, 16'h9008, 16'h9E04, 16'h1D05};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 0, stop = 0, bv = 0, take = 0, awe = 0;
   logic [7:0] bdat = 8'h00, aptr = 8'h00;
   logic ack64, ack48, sel64, sel48;
   logic [7:0] rd64, rd48, ptr64, ptr48;
   int n_chk = 0, n_err = 0;

   always #2 clk = ~clk;

   ext_id_reader #(.SERIAL_NUM(SN), .EXT_ID(EXT), .EUI64(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .strap_i(STRAP), .start_i(start), .stop_i(stop),
      .byte_valid_i(bv), .byte_i(bdat), .tx_take_i(take), .arr_ptr_we_i(awe),
      .arr_ptr_i(aptr), .ack_o(ack64), .sel_o(sel64), .rd_data_o(rd64), .ptr_o(ptr64));

   ext_id_reader #(.SERIAL_NUM(SN), .EXT_ID(EXT), .EUI64(1'b0)) dut48_i (
      .clk(clk), .rst_n(rst_n), .strap_i(STRAP), .start_i(start), .stop_i(stop),
      .byte_valid_i(bv), .byte_i(bdat), .tx_take_i(take), .arr_ptr_we_i(awe),
      .arr_ptr_i(aptr), .ack_o(ack48), .sel_o(sel48), .rd_data_o(rd48), .ptr_o(ptr48));

   function automatic logic [7:0] exp64(input int idx);
      if (idx < 16) return 8'(8'h11 * idx);
      case (idx)
         24: return 8'hFC; 25: return 8'hC2; 26: return 8'h3D;
         27: return 8'h0A; 28: return 8'h1B; 29: return 8'h2C;
         30: return 8'h3D; 31: return 8'h4E;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] exp48(input int idx);
      if (idx < 16) return 8'(8'h11 * idx);
      case (idx)
         26: return 8'hFC; 27: return 8'hC2; 28: return 8'h3D;
         29: return 8'h2C; 30: return 8'h3D; 31: return 8'h4E;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic string tag_of(input int idx);
      if (idx < 16) return "R3 serial";
      if (idx >= 24) return "R4/R5 identifier";
      return "R5 gap";
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic cyc;
      @(posedge clk);
      #1;
   endtask

   task automatic do_start;
      start = 1; cyc; start = 0;
   endtask

   task automatic do_stop;
      stop = 1; cyc; stop = 0;
   endtask

   task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
      bv = 1; bdat = b;
      #1;
      chk(tag, {7'd0, ack64}, {7'd0, exp_ack});
      chk(tag, {7'd0, ack48}, {7'd0, exp_ack});
      cyc;
      bv = 0;
   endtask

   task automatic rd(input int idx);
      #1;
      chk(tag_of(idx), rd64, exp64(idx));
      chk(tag_of(idx), rd48, exp48(idx));
      take = 1; cyc; take = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cyc;
      // R11 reset state
      chk("R11 ptr", ptr64, 8'h00);
      chk("R11 sel", {7'd0, sel64}, 8'h00);
      chk("R11 ack", {7'd0, ack64}, 8'h00);

      // R1 wrong control code and wrong strap are refused
      do_start;
      send({4'hA, STRAP, 1'b1}, 1'b0, "R1 code");
      chk("R1 sel", {7'd0, sel64}, 8'h00);
      do_start;
      send({4'hB, 3'b010, 1'b1}, 1'b0, "R1 strap");
      chk("R1 sel", {7'd0, sel64}, 8'h00);
      do_stop;

      // table: dummy write then sequential read
      for (int v = 0; v < NVEC; v++) begin
         logic [7:0] wa;
         int n, idx;
         wa = VEC[v][15:8];
         n = int'(VEC[v][7:0]);
         do_start;
         send(DEV_W, 1'b1, "R1 write select");
         send(wa, 1'b1, "R2 word address");
         chk("R2 pointer", ptr64, 8'h80 | {3'b000, wa[4:0]});
         do_start;
         send(DEV_R, 1'b1, "R1 read select");
         chk("R1 selected", {7'd0, sel64}, 8'h01);
         idx = int'(wa[4:0]);
         for (int k = 0; k < n; k++) begin
            rd(idx);
            idx = (idx + 1) % 32;
         end
         chk("R6 pointer after stream", ptr64, 8'h80 | 8'(idx));
         chk("R6 pointer after stream", ptr48, 8'h80 | 8'(idx));
         do_stop;
      end

      // R8 write data refused, pointer and contents kept
      do_start;
      send(DEV_W, 1'b1, "R8 setup");
      send(8'h85, 1'b1, "R8 setup");
      send(8'h55, 1'b0, "R8 data byte");
      chk("R8 pointer", ptr64, 8'h85);
      do_start;
      send(DEV_R, 1'b1, "R8 read back");
      send(8'h77, 1'b0, "R8 byte during read");
      chk("R8 pointer in read", ptr64, 8'h85);
      rd(5);
      do_stop;

      // R7 current-address read after a main-array access
      awe = 1; aptr = 8'h4C; cyc; awe = 0;
      chk("R7 main load", ptr64, 8'h4C);
      do_start;
      send(DEV_R, 1'b1, "R7 read select");
      chk("R7 forced pointer", ptr64, 8'h8C);
      rd(12);
      chk("R7 next pointer", ptr64, 8'h8D);

      // R9 same-cycle increment and main-array load
      take = 1; awe = 1; aptr = 8'h10; cyc; take = 0; awe = 0;
      chk("R9 collision", ptr64, 8'h8E);
      awe = 1; aptr = 8'h33; cyc; awe = 0;
      chk("R9 load while selected", ptr64, 8'h8E);
      rd(14);

      // R10 stop deselects; take has no effect afterwards
      do_stop;
      chk("R10 sel", {7'd0, sel64}, 8'h00);
      chk("R10 data", rd64, 8'hFF);
      take = 1; cyc; take = 0;
      chk("R10 pointer", ptr64, 8'h8F);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule